// File: doc/BRIEF.md
# Multicast Destination List Expander

The block turns a 256-bit destination bitmap into a stream of unicast node IDs. A descriptor is presented on a load port with the bitmap, a 15-bit base node ID, a multi-level mode flag and a subnode ID. When the descriptor is valid for endpoint multi-unicast delivery, the block walks the bitmap from bit 0 upwards. It emits one node ID for each set bit on a valid/ready output stream and marks the final one.

Bitmap positions stand for even node IDs spaced two apart. The node ID for set bit `i` is therefore `base + 2*i`, truncated to 15 bits. A descriptor whose bitmap is empty ends at once with a completion pulse. A descriptor that requests multi-level routing, or that carries a subnode ID other than 0x10, is refused with an error pulse and produces no output. A new descriptor can be accepted in the same cycle that the completion pulse of the previous one is high.

Top module: `mcast_dest_expander`

## Requirements
- R1: After reset, `ld_ready` is 1 and `out_valid`, `done` and `err` are 0.
- R2: A descriptor is taken only when `ld_valid` and `ld_ready` are both 1. `ld_ready` is 0 from the cycle after acceptance of a non-empty, well-formed descriptor until its last destination has been accepted.
- R3: Each emitted `out_node` equals `(base + 2*i) mod 2^15`, where `i` is the bit index of the set bit it stands for and `base` is the `ld_base` value captured at load.
- R4: Exactly one destination is emitted per set bit, in ascending bit order. The first one appears two clock edges after the load edge.
- R5: `out_last` is 1 on the destination for the highest set bit and 0 on every other destination.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_node` and `out_last` hold their values at the next edge.
- R7: `done` is high for one cycle, in the cycle after the edge at which the last destination is accepted. `out_valid` is 0 in that cycle.
- R8: An all-zero bitmap in a well-formed descriptor raises `done` in the cycle after the load edge and emits no destination.
- R9: A descriptor with `ld_multi` = 1 raises `err` for one cycle after the load edge. It emits no destination, does not raise `done`, and leaves `ld_ready` at 1.
- R10: A descriptor with `ld_subnode` other than 0x10 behaves as in R9.
- R11: `ld_ready` is 1 in the `done` cycle, and a descriptor loaded in that cycle is expanded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Descriptor present on the load port |
| ld_ready | output | 1 | Block is idle and will take a descriptor |
| ld_vec | input | VEC_W | Destination bitmap, bit 0 first |
| ld_base | input | NODE_W | Node ID of bitmap bit 0 |
| ld_multi | input | 1 | Multi-level routing request (must be 0) |
| ld_subnode | input | SUB_W | Destination subnode ID (must be 0x10) |
| out_valid | output | 1 | Destination node ID is valid |
| out_ready | input | 1 | Consumer takes the destination |
| out_node | output | NODE_W | Destination node ID |
| out_last | output | 1 | This destination is the final one of the descriptor |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse for a malformed descriptor |

## Verification
The completion of one descriptor and the acceptance of the next can fall in the same cycle, because the block is idle again while `done` is high. The bench provokes this on every descriptor of its sweeps by presenting the next load at the very sampling point where it expects `done`. It judges the overlap by checking that `done` is seen, that `ld_ready` is 1, and that the following descriptor's whole destination list matches the arithmetic expectation under three back-pressure patterns. The empty-bitmap case stacks the same overlap on consecutive cycles.

// File: rtl/mdx_pkg.sv
package mdx_pkg;
  localparam int DEF_VEC_W       = 256;
  localparam int DEF_NODE_W      = 15;
  localparam int DEF_SUB_W       = 6;
  localparam int DEF_SUB_REQ     = 16;
  localparam int DEF_STRIDE_LOG2 = 1;
endpackage

// File: rtl/mdx_low_bit_find.sv
module mdx_low_bit_find #(
  parameter int VEC_W = 256,
  parameter int IDX_W = $clog2(VEC_W)
) (
  input  logic [VEC_W-1:0] vec,
  output logic [VEC_W-1:0] onehot,
  output logic [IDX_W-1:0] idx
);
  assign onehot = vec & (~vec + VEC_W'(1));

  for (genvar b = 0; b < IDX_W; b++) begin : g_bit
    logic [VEC_W-1:0] sel;
    for (genvar j = 0; j < VEC_W; j++) begin : g_pos
      if (((j >> b) & 1) == 1) begin : g_on
        assign sel[j] = onehot[j];
      end else begin : g_off
        assign sel[j] = 1'b0;
      end
    end
    assign idx[b] = |sel;
  end
endmodule

// File: rtl/mdx_hdr_check.sv
module mdx_hdr_check #(
  parameter int SUB_W   = 6,
  parameter int SUB_REQ = 16
) (
  input  logic             multi,
  input  logic [SUB_W-1:0] subnode,
  output logic             ok
);
  assign ok = !multi && (subnode == SUB_W'(SUB_REQ));
endmodule

// File: rtl/mdx_node_calc.sv
module mdx_node_calc #(
  parameter int NODE_W      = 15,
  parameter int IDX_W       = 8,
  parameter int STRIDE_LOG2 = 1
) (
  input  logic [NODE_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  output logic [NODE_W-1:0] node
);
  localparam int SUM_W = NODE_W + IDX_W + STRIDE_LOG2 + 1;
  logic [SUM_W-1:0] sum;

  assign sum  = SUM_W'(base) + (SUM_W'(idx) << STRIDE_LOG2);
  assign node = sum[NODE_W-1:0];
endmodule

// File: rtl/mcast_dest_expander.sv
module mcast_dest_expander
  import mdx_pkg::*;
#(
  parameter int VEC_W       = DEF_VEC_W,
  parameter int NODE_W      = DEF_NODE_W,
  parameter int SUB_W       = DEF_SUB_W,
  parameter int SUB_REQ     = DEF_SUB_REQ,
  parameter int STRIDE_LOG2 = DEF_STRIDE_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [VEC_W-1:0]  ld_vec,
  input  logic [NODE_W-1:0] ld_base,
  input  logic              ld_multi,
  input  logic [SUB_W-1:0]  ld_subnode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NODE_W-1:0] out_node,
  output logic              out_last,
  output logic              done,
  output logic              err
);
  localparam int IDX_W = $clog2(VEC_W);

  logic              busy_q;
  logic [VEC_W-1:0]  rem_q;
  logic [NODE_W-1:0] base_q;
  logic              vld_q;
  logic [NODE_W-1:0] node_q;
  logic              last_q;
  logic              done_q;
  logic              err_q;

  logic              hdr_ok;
  logic [VEC_W-1:0]  low_onehot;
  logic [IDX_W-1:0]  low_idx;
  logic [NODE_W-1:0] next_node;
  logic [VEC_W-1:0]  rem_next;
  logic              load_fire;
  logic              take_last;
  logic              advance;

  mdx_hdr_check #(
    .SUB_W   (SUB_W),
    .SUB_REQ (SUB_REQ)
  ) u_hdr (
    .multi   (ld_multi),
    .subnode (ld_subnode),
    .ok      (hdr_ok)
  );

  mdx_low_bit_find #(
    .VEC_W (VEC_W),
    .IDX_W (IDX_W)
  ) u_find (
    .vec    (rem_q),
    .onehot (low_onehot),
    .idx    (low_idx)
  );

  mdx_node_calc #(
    .NODE_W      (NODE_W),
    .IDX_W       (IDX_W),
    .STRIDE_LOG2 (STRIDE_LOG2)
  ) u_calc (
    .base (base_q),
    .idx  (low_idx),
    .node (next_node)
  );

  assign load_fire = ld_valid && !busy_q;
  assign rem_next  = rem_q & ~low_onehot;
  assign take_last = vld_q && out_ready && last_q;
  assign advance   = busy_q && (rem_q != '0) && (!vld_q || out_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
      base_q <= '0;
      vld_q  <= 1'b0;
      node_q <= '0;
      last_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (load_fire) begin
        if (!hdr_ok) begin
          err_q <= 1'b1;
        end else if (ld_vec == '0) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          rem_q  <= ld_vec;
          base_q <= ld_base;
        end
      end
      if (busy_q) begin
        if (take_last) begin
          vld_q  <= 1'b0;
          last_q <= 1'b0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else if (advance) begin
          vld_q  <= 1'b1;
          node_q <= next_node;
          last_q <= (rem_next == '0);
          rem_q  <= rem_next;
        end
      end
    end
  end

  assign ld_ready  = !busy_q;
  assign out_valid = vld_q;
  assign out_node  = node_q;
  assign out_last  = last_q;
  assign done      = done_q;
  assign err       = err_q;
endmodule

// File: rtl/mdx_chk.sv
module mdx_chk #(
  parameter int NODE_W  = 15,
  parameter int SUB_W   = 6,
  parameter int SUB_REQ = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_valid,
  input logic              ld_ready,
  input logic              ld_multi,
  input logic [SUB_W-1:0]  ld_subnode,
  input logic              out_valid,
  input logic              out_ready,
  input logic [NODE_W-1:0] out_node,
  input logic              out_last,
  input logic              done,
  input logic              err
);
  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_node) && $stable(out_last)));

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> (done && !out_valid));

  // R9
  multi_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_ready && ld_multi) |=> (err && !done && !out_valid && ld_ready));

  // R10
  subnode_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_ready && (ld_subnode != SUB_W'(SUB_REQ))) |=> (err && !out_valid));

  // R2
  busy_no_load_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !ld_ready);

  // R9
  err_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(err && done));
endmodule

bind mcast_dest_expander mdx_chk #(
  .NODE_W  (NODE_W),
  .SUB_W   (SUB_W),
  .SUB_REQ (SUB_REQ)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ld_valid   (ld_valid),
  .ld_ready   (ld_ready),
  .ld_multi   (ld_multi),
  .ld_subnode (ld_subnode),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_node   (out_node),
  .out_last   (out_last),
  .done       (done),
  .err        (err)
);

// File: tb/mcast_dest_expander_tb.sv
module mcast_dest_expander_tb;
  localparam int W  = 8;
  localparam int NW = 15;
  localparam int SW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_valid = 1'b0;
  logic          ld_ready;
  logic [W-1:0]  ld_vec = '0;
  logic [NW-1:0] ld_base = '0;
  logic          ld_multi = 1'b0;
  logic [SW-1:0] ld_subnode = 6'h10;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [NW-1:0] out_node;
  logic          out_last;
  logic          done;
  logic          err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mcast_dest_expander #(
    .VEC_W  (W),
    .NODE_W (NW),
    .SUB_W  (SW)
  ) u_dut (
    .clk        (clk),
    .rst        (rst),
    .ld_valid   (ld_valid),
    .ld_ready   (ld_ready),
    .ld_vec     (ld_vec),
    .ld_base    (ld_base),
    .ld_multi   (ld_multi),
    .ld_subnode (ld_subnode),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_node   (out_node),
    .out_last   (out_last),
    .done       (done),
    .err        (err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drives a load at the current negedge and follows the stream to done.
  task automatic expand(input logic [W-1:0] v, input logic [NW-1:0] b, input int mode);
    int cyc = 0;
    ld_valid = 1'b1; ld_vec = v; ld_base = b; ld_multi = 1'b0; ld_subnode = 6'h10;
    chk("R11 ld_ready at load", int'(ld_ready), 1);
    @(negedge clk);
    ld_valid = 1'b0;
    if (v == '0) begin
      chk("R8 done on empty", int'(done), 1);
      chk("R8 no output on empty", int'(out_valid), 0);
      return;
    end
    chk("R4 first output not yet valid", int'(out_valid), 0);
    for (int i = 0; i < W; i++) begin
      if (v[i]) begin
        bit acc = 1'b0;
        while (!acc) begin
          if (out_valid) begin
            int exp_node = (int'(b) + 2 * i) % 32768;
            int exp_last = ((v >> (i + 1)) == '0) ? 1 : 0;
            logic [NW-1:0] held;
            bit rdy;
            chk("R3 R4 node", int'(out_node), exp_node);
            chk("R5 last marker", int'(out_last), exp_last);
            chk("R2 ld_ready low while busy", int'(ld_ready), 0);
            rdy = (mode == 0) ? 1'b1 : (mode == 1) ? bit'(cyc % 2) : bit'(cyc % 3 != 0);
            out_ready = rdy;
            held = out_node;
            @(negedge clk);
            cyc++;
            if (rdy) acc = 1'b1;
            else begin
              chk("R6 valid held", int'(out_valid), 1);
              chk("R6 node held", int'(out_node), int'(held));
            end
          end else begin
            out_ready = 1'b0;
            @(negedge clk);
            cyc++;
          end
        end
      end
    end
    out_ready = 1'b0;
    chk("R7 done after last", int'(done), 1);
    chk("R7 no output in done cycle", int'(out_valid), 0);
  endtask

  task automatic reject(input logic multi, input logic [SW-1:0] sub, input string req);
    ld_valid = 1'b1; ld_vec = 8'hA5; ld_base = 15'h0100; ld_multi = multi; ld_subnode = sub;
    @(negedge clk);
    ld_valid = 1'b0; ld_multi = 1'b0; ld_subnode = 6'h10;
    chk({req, " err pulse"}, int'(err), 1);
    chk({req, " no done"}, int'(done), 0);
    chk({req, " no output"}, int'(out_valid), 0);
    chk({req, " still ready"}, int'(ld_ready), 1);
    @(negedge clk);
    chk({req, " err one cycle"}, int'(err), 0);
    chk({req, " no output later"}, int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 ld_ready", int'(ld_ready), 1);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 err", int'(err), 0);

    for (int m = 0; m < 3; m++) begin
      logic [NW-1:0] b;
      b = (m == 0) ? 15'h0000 : (m == 1) ? 15'h1235 : 15'h7FFA;
      for (int v = 0; v < 256; v++) expand(W'(v), b, m);
    end
    @(negedge clk);
    chk("R7 done one cycle", int'(done), 0);

    reject(1'b1, 6'h10, "R9");
    reject(1'b0, 6'h00, "R10");
    reject(1'b0, 6'h11, "R10");
    reject(1'b0, 6'h3F, "R10");
    reject(1'b1, 6'h30, "R9");
    expand(8'h81, 15'h7FFF, 2);
    expand(8'h00, 15'h0002, 0);
    expand(8'hFF, 15'h4000, 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule